// File: doc/BRIEF.md
# Serial EEPROM Self-Timed Program Engine

This block sits behind the shift-register front-end of a three-wire serial EEPROM. It holds the 4 Kbit storage array and runs the self-timed erase and program cycles that the front-end hands over as decoded commands. The six commands are: clear one word, clear the whole array, program one word, program the whole array, enable programming and disable programming. The front-end reads the array directly through a combinational read port. The front-end also passes on the chip-select level and a pulse for each start bit it detects.

A program-enable latch guards every array-changing command and comes out of reset cleared. Every cycle is timed in system clocks. Program-word and program-all spend the first half of their time clearing the target to all ones and the second half writing the data. A parameter picks the moment a cycle begins: either the deselect edge after the last bit, or the clock edge that delivers the last bit. The serial data-out line is modelled as an enable plus a value. It reports busy (0) or ready (1) when chip select is raised after a long enough low period.

Top module: `eeprom_prog_engine`

## Requirements
- R1: After reset `busy` is 0, `sdo_en` is 0 and programming is disabled. Commands with `cmd_op` codes 1 to 4 start no cycle until an enable command (code 5) has been accepted.
- R2: Programming stays enabled until a disable command (code 6) or reset. The read port returns stored data in either enable state.
- R3: Clear-word (code 1) sets every bit of the addressed word to 1 and leaves other words unchanged. Clear-all (code 2) sets every bit of the array to 1.
- R4: Program-word (code 3) and program-all (code 4) erase their target first. The target reads all ones once the first half (rounded down) of the cycle time has passed, and reads the new data at the end. Program-all writes every word without a prior clear-all.
- R5: With `START_ON_DESELECT`=1 a cycle starts at the first clock edge that sees `chip_sel` low after the command. With 0 it starts on the clock edge that accepts the command. `busy` stays high for exactly T_WORD (codes 1 and 3), T_CLR_ALL (code 2) or T_PROG_ALL (code 4) clocks.
- R6: When `chip_sel` rises after being low for at least MIN_CS_LOW clock edges, and a cycle has started since the last clear, `sdo_en` goes high one clock later. `sdo_val` is then 0 while busy and 1 when ready. `sdo_en` drops as soon as `chip_sel` is low. A shorter low period gives no status.
- R7: A started cycle runs to its normal end and commits its data whatever `chip_sel` does during it.
- R8: A start bit followed by `chip_sel` going low, with no complete command in between, withdraws the status: a later qualifying rise of `chip_sel` leaves `sdo_en` at 0.
- R9: With `wide_mode`=1 a word is 16 bits and `cmd_addr[7:0]` selects it (bit 8 is ignored). With `wide_mode`=0 a word is 8 bits at byte address `cmd_addr[8:0]`: byte address 2k+1 is the upper half of 16-bit word k and 2k is its lower half, and `rd_data[15:8]` reads 0.
- R10: A program or clear command that arrives while `busy` is high is dropped. The running cycle keeps its length and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| chip_sel | input | 1 | Chip-select level from the serial pins |
| start_bit | input | 1 | One-clock pulse when the front-end sees a start bit |
| cmd_valid | input | 1 | One-clock pulse with a complete decoded command |
| cmd_op | input | 3 | Command code (1 to 6, see requirements) |
| cmd_addr | input | 9 | Word or byte address of the command |
| cmd_data | input | 16 | Program data (low byte used in 8-bit mode) |
| rd_addr | input | 9 | Read address, interpreted per `wide_mode` |
| rd_data | output | 16 | Read data |
| busy | output | 1 | A self-timed cycle is running |
| sdo_en | output | 1 | Data-out line driven with status |
| sdo_val | output | 1 | Status value: 0 busy, 1 ready |

## Verification
A wrong enable latch or a lost pending command shows up on `busy` within one clock of the deselect edge or accepting edge. A miscounted timer shows up as a busy pulse that is short or long by whole clocks, and the bench measures the pulse edge-exactly. A bad phase split or a bad address map shows up on the read port: mid-cycle against the all-ones erase image, and after the cycle against a bench model of every word. A stale status flag reaches `sdo_en` one clock after the next qualifying rise of chip select.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
   localparam int unsigned EE_ADDR_W = 9;
   localparam int unsigned EE_DATA_W = 16;

   typedef enum logic [2:0] {
      OP_IDLE       = 3'd0,
      OP_CLEAR_WORD = 3'd1,
      OP_CLEAR_ALL  = 3'd2,
      OP_PROG_WORD  = 3'd3,
      OP_PROG_ALL   = 3'd4,
      OP_WR_ENABLE  = 3'd5,
      OP_WR_DISABLE = 3'd6
   } ee_op_e;

   typedef struct packed {
      ee_op_e                 op;
      logic [EE_ADDR_W-1:0]   addr;
      logic [EE_DATA_W-1:0]   data;
      logic                   wide;
   } ee_job_t;

   // true for commands that change the array
   function automatic logic op_changes_array(input ee_op_e op);
      return (op == OP_CLEAR_WORD) || (op == OP_CLEAR_ALL) ||
             (op == OP_PROG_WORD)  || (op == OP_PROG_ALL);
   endfunction

   // true for commands that have a program phase after the erase phase
   function automatic logic op_has_prog(input ee_op_e op);
      return (op == OP_PROG_WORD) || (op == OP_PROG_ALL);
   endfunction

   // true for commands that touch every word
   function automatic logic op_whole_array(input ee_op_e op);
      return (op == OP_CLEAR_ALL) || (op == OP_PROG_ALL);
   endfunction
endpackage

// File: rtl/eeprom_cmd_gate.sv
module eeprom_cmd_gate
   import eeprom_pkg::*;
#(
   parameter bit START_ON_DESELECT = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmd_valid,
   input  ee_job_t cmd_job,
   input  logic    cs_fall,
   input  logic    busy,
   output logic    wel,
   output logic    start,
   output ee_job_t job
);
   logic accept;

   // program-enable latch, cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (cmd_valid) begin
         if (cmd_job.op == OP_WR_ENABLE)       wel <= 1'b1;
         else if (cmd_job.op == OP_WR_DISABLE) wel <= 1'b0;
      end
   end

   assign accept = cmd_valid && op_changes_array(cmd_job.op) && wel && !busy;

   generate
      if (START_ON_DESELECT) begin : g_on_deselect
         logic    pend_v;
         ee_job_t pend_job;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_v   <= 1'b0;
               pend_job <= '0;
            end else if (cs_fall) begin
               pend_v <= 1'b0;
            end else if (cmd_valid && cmd_job.op == OP_WR_DISABLE) begin
               pend_v <= 1'b0;
            end else if (accept) begin
               pend_v   <= 1'b1;
               pend_job <= cmd_job;
            end
         end

         assign start = pend_v && cs_fall && !busy;
         assign job   = pend_job;
      end else begin : g_on_last_bit
         assign start = accept;
         assign job   = cmd_job;
      end
   endgenerate
endmodule

// File: rtl/eeprom_cycle_timer.sv
module eeprom_cycle_timer
   import eeprom_pkg::*;
#(
   parameter int unsigned T_WORD     = 6000,
   parameter int unsigned T_CLR_ALL  = 6000,
   parameter int unsigned T_PROG_ALL = 15000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  ee_job_t job_i,
   output logic    busy,
   output ee_job_t job_o,
   output logic    erase_stb,
   output logic    prog_stb
);
   localparam int unsigned T_MAX_A = (T_WORD > T_CLR_ALL) ? T_WORD : T_CLR_ALL;
   localparam int unsigned T_MAX   = (T_MAX_A > T_PROG_ALL) ? T_MAX_A : T_PROG_ALL;
   localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

   typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} phase_e;

   phase_e           phase;
   logic [CNT_W-1:0] cnt;

   function automatic int unsigned full_len(input ee_op_e op);
      case (op)
         OP_CLEAR_ALL: return T_CLR_ALL;
         OP_PROG_ALL:  return T_PROG_ALL;
         default:      return T_WORD;
      endcase
   endfunction

   function automatic int unsigned erase_len(input ee_op_e op);
      return op_has_prog(op) ? full_len(op) / 2 : full_len(op);
   endfunction

   function automatic int unsigned prog_len(input ee_op_e op);
      return full_len(op) - full_len(op) / 2;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         job_o <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  job_o <= job_i;
                  phase <= PH_ERASE;
                  cnt   <= CNT_W'(erase_len(job_i.op) - 1);
               end
            end
            PH_ERASE: begin
               if (cnt == '0) begin
                  if (op_has_prog(job_o.op)) begin
                     phase <= PH_PROG;
                     cnt   <= CNT_W'(prog_len(job_o.op) - 1);
                  end else begin
                     phase <= PH_IDLE;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_PROG: begin
               if (cnt == '0) phase <= PH_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (phase != PH_IDLE);
   assign erase_stb = (phase == PH_ERASE) && (cnt == '0);
   assign prog_stb  = (phase == PH_PROG)  && (cnt == '0);
endmodule

// File: rtl/eeprom_status.sv
module eeprom_status #(
   parameter int unsigned MIN_CS_LOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic start_bit,
   input  logic cmd_valid,
   input  logic cycle_start,
   input  logic busy,
   output logic cs_fall,
   output logic status_avail,
   output logic sdo_en,
   output logic sdo_val
);
   localparam int unsigned LOW_W = $clog2(MIN_CS_LOW + 1);

   logic             cs_q;
   logic             cs_rise;
   logic [LOW_W-1:0] low_cnt;
   logic             show;
   logic             clr_arm;

   assign cs_fall = cs_q && !chip_sel;
   assign cs_rise = chip_sel && !cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q         <= 1'b0;
         low_cnt      <= '0;
         show         <= 1'b0;
         clr_arm      <= 1'b0;
         status_avail <= 1'b0;
      end else begin
         cs_q <= chip_sel;

         // saturating count of edges with select low
         if (chip_sel)                                low_cnt <= '0;
         else if (low_cnt != LOW_W'(MIN_CS_LOW))      low_cnt <= low_cnt + 1'b1;

         // a start bit with no complete command arms the clear
         if (cmd_valid || cs_fall)      clr_arm <= 1'b0;
         else if (start_bit && chip_sel) clr_arm <= 1'b1;

         if (cycle_start)               status_avail <= 1'b1;
         else if (cs_fall && clr_arm)   status_avail <= 1'b0;

         if (cs_fall)
            show <= 1'b0;
         else if (cs_rise && low_cnt == LOW_W'(MIN_CS_LOW) && (status_avail || cycle_start))
            show <= 1'b1;
      end
   end

   assign sdo_en  = show && chip_sel;
   assign sdo_val = sdo_en && !busy;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
   import eeprom_pkg::*;
#(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              erase_stb,
   input  logic              prog_stb,
   input  ee_job_t           job,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_wide,
   output logic [WORD_W-1:0] rd_data
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned HALF  = WORD_W / 2;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  w_idx;
   logic [WORD_W-1:0] w_mask;
   logic [WORD_W-1:0] w_fill;
   logic [IDX_W-1:0]  r_idx;
   logic [WORD_W-1:0] r_word;

   function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a, input logic wide);
      return wide ? a[IDX_W-1:0] : a[IDX_W:1];
   endfunction

   function automatic logic [WORD_W-1:0] lane_mask(input logic [ADDR_W-1:0] a, input logic wide);
      if (wide)      return '1;
      else if (a[0]) return {{HALF{1'b1}}, {HALF{1'b0}}};
      else           return {{HALF{1'b0}}, {HALF{1'b1}}};
   endfunction

   assign w_idx  = word_of(job.addr, job.wide);
   assign w_mask = lane_mask(job.addr, job.wide);
   assign w_fill = job.wide ? job.data : {2{job.data[HALF-1:0]}};

   always_ff @(posedge clk) begin
      if (erase_stb) begin
         if (op_whole_array(job.op)) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         end else begin
            mem[w_idx] <= mem[w_idx] | w_mask;
         end
      end
      if (prog_stb) begin
         if (op_whole_array(job.op)) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= w_fill;
         end else begin
            mem[w_idx] <= (mem[w_idx] & ~w_mask) | (w_fill & w_mask);
         end
      end
   end

   assign r_idx  = word_of(rd_addr, rd_wide);
   assign r_word = mem[r_idx];

   always_comb begin
      if (rd_wide)         rd_data = r_word;
      else if (rd_addr[0]) rd_data = {{HALF{1'b0}}, r_word[WORD_W-1:HALF]};
      else                 rd_data = {{HALF{1'b0}}, r_word[HALF-1:0]};
   end
endmodule

// File: rtl/eeprom_prog_engine.sv
module eeprom_prog_engine
   import eeprom_pkg::*;
#(
   parameter int unsigned ARRAY_BITS        = 4096,
   parameter int unsigned WORD_W            = 16,
   parameter int unsigned ADDR_W            = 9,
   parameter int unsigned T_WORD            = 6000,
   parameter int unsigned T_CLR_ALL         = 6000,
   parameter int unsigned T_PROG_ALL        = 15000,
   parameter int unsigned MIN_CS_LOW        = 4,
   parameter bit          START_ON_DESELECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic              chip_sel,
   input  logic              start_bit,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] cmd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              busy,
   output logic              sdo_en,
   output logic              sdo_val
);
   localparam int unsigned DEPTH = ARRAY_BITS / WORD_W;
   localparam int unsigned IDX_W = $clog2(DEPTH);

   if (WORD_W != EE_DATA_W || ADDR_W != EE_ADDR_W) begin : g_bad_width
      $error("eeprom_prog_engine: widths must match eeprom_pkg");
   end
   if (ADDR_W != IDX_W + 1 || (WORD_W % 2) != 0) begin : g_bad_geom
      $error("eeprom_prog_engine: byte address must be one bit wider than word index");
   end
   if (T_WORD < 4 || T_CLR_ALL < 4 || T_PROG_ALL < 4 || MIN_CS_LOW < 1) begin : g_bad_time
      $error("eeprom_prog_engine: cycle times must be at least 4 clocks");
   end

   ee_job_t in_job;
   ee_job_t start_job;
   ee_job_t act_job;
   logic    wel_q;
   logic    cycle_start;
   logic    cs_fall;
   logic    status_avail;
   logic    erase_stb;
   logic    prog_stb;

   assign in_job = '{op: ee_op_e'(cmd_op), addr: cmd_addr, data: cmd_data, wide: wide_mode};

   eeprom_cmd_gate #(
      .START_ON_DESELECT(START_ON_DESELECT)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_job   (in_job),
      .cs_fall   (cs_fall),
      .busy      (busy),
      .wel       (wel_q),
      .start     (cycle_start),
      .job       (start_job)
   );

   eeprom_cycle_timer #(
      .T_WORD     (T_WORD),
      .T_CLR_ALL  (T_CLR_ALL),
      .T_PROG_ALL (T_PROG_ALL)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cycle_start),
      .job_i     (start_job),
      .busy      (busy),
      .job_o     (act_job),
      .erase_stb (erase_stb),
      .prog_stb  (prog_stb)
   );

   eeprom_status #(
      .MIN_CS_LOW(MIN_CS_LOW)
   ) u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_sel     (chip_sel),
      .start_bit    (start_bit),
      .cmd_valid    (cmd_valid),
      .cycle_start  (cycle_start),
      .busy         (busy),
      .cs_fall      (cs_fall),
      .status_avail (status_avail),
      .sdo_en       (sdo_en),
      .sdo_val      (sdo_val)
   );

   eeprom_array #(
      .DEPTH  (DEPTH),
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) u_array (
      .clk       (clk),
      .erase_stb (erase_stb),
      .prog_stb  (prog_stb),
      .job       (act_job),
      .rd_addr   (rd_addr),
      .rd_wide   (wide_mode),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/eeprom_prog_checker.sv
module eeprom_prog_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic wel,
   input logic cycle_start,
   input logic chip_sel,
   input logic sdo_en,
   input logic sdo_val,
   input logic status_avail
);
   a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |-> wel);

   a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |-> !busy);

   a_r5_busy_spans_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

   a_r6_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_en |-> chip_sel);

   a_r6_ready_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && !busy) |-> sdo_val);

   a_r6_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && busy) |-> !sdo_val);

   a_r8_start_posts_status: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |=> status_avail);
endmodule

bind eeprom_prog_engine eeprom_prog_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .wel          (wel_q),
   .cycle_start  (cycle_start),
   .chip_sel     (chip_sel),
   .sdo_en       (sdo_en),
   .sdo_val      (sdo_val),
   .status_avail (status_avail)
);

// File: tb/eeprom_prog_engine_tb.sv
module eeprom_prog_engine_tb;
   import eeprom_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int T_W  = 40;
   localparam int T_CA = 30;
   localparam int T_PA = 60;
   localparam int MINL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b1;
   logic        chip_sel = 1'b0;
   logic        start_bit = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [8:0]  cmd_addr = '0;
   logic [15:0] cmd_data = '0;
   logic [8:0]  rd_addr = '0;
   logic [15:0] rd_data, rd_data_e;
   logic        busy, busy_e, sdo_en, sdo_en_e, sdo_val, sdo_val_e;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_prog_engine #(.T_WORD(T_W), .T_CLR_ALL(T_CA), .T_PROG_ALL(T_PA),
                        .MIN_CS_LOW(MINL), .START_ON_DESELECT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .chip_sel(chip_sel),
      .start_bit(start_bit), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .sdo_en(sdo_en), .sdo_val(sdo_val));

   eeprom_prog_engine #(.T_WORD(T_W), .T_CLR_ALL(T_CA), .T_PROG_ALL(T_PA),
                        .MIN_CS_LOW(MINL), .START_ON_DESELECT(1'b0)) u_dut_edge (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .chip_sel(chip_sel),
      .start_bit(start_bit), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
      .rd_data(rd_data_e), .busy(busy_e), .sdo_en(sdo_en_e), .sdo_val(sdo_val_e));

   logic [15:0] mdl [256];
   bit          wel_m;
   int          n_chk = 0;
   int          n_err = 0;
   bit          finished = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic nstep(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int len_of(input ee_op_e op);
      case (op)
         OP_CLEAR_ALL: return T_CA;
         OP_PROG_ALL:  return T_PA;
         default:      return T_W;
      endcase
   endfunction

   function automatic logic [7:0] widx(input logic [8:0] a, input logic w);
      return w ? a[7:0] : a[8:1];
   endfunction

   function automatic logic [15:0] wmask(input logic [8:0] a, input logic w);
      return w ? 16'hFFFF : (a[0] ? 16'hFF00 : 16'h00FF);
   endfunction

   function automatic logic [15:0] exp_read(input logic [8:0] a, input logic w);
      logic [15:0] v = mdl[widx(a, w)];
      if (w) return v;
      return a[0] ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
   endfunction

   task automatic model_apply(input ee_op_e op, input logic [8:0] a, input logic [15:0] d, input logic w);
      logic [15:0] fill = w ? d : {d[7:0], d[7:0]};
      logic [15:0] m = wmask(a, w);
      case (op)
         OP_CLEAR_WORD: mdl[widx(a, w)] = mdl[widx(a, w)] | m;
         OP_CLEAR_ALL:  for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
         OP_PROG_WORD:  mdl[widx(a, w)] = (mdl[widx(a, w)] & ~m) | (fill & m);
         OP_PROG_ALL:   for (int i = 0; i < 256; i++) mdl[i] = fill;
         default: ;
      endcase
   endtask

   // start bit, command, then deselect; returns just before the deselect edge
   task automatic issue(input ee_op_e op, input logic [8:0] a, input logic [15:0] d, input logic w);
      @(negedge clk);
      chip_sel = 1'b1; start_bit = 1'b1;
      @(negedge clk);
      start_bit = 1'b0; cmd_valid = 1'b1; cmd_op = op;
      cmd_addr = a; cmd_data = d; wide_mode = w;
      @(negedge clk);
      cmd_valid = 1'b0; chip_sel = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [8:0] a, input logic w);
      wide_mode = w; rd_addr = a;
      #1;
      check(tag, rd_data, exp_read(a, w));
      check(tag, rd_data_e, exp_read(a, w));
   endtask

   task automatic run_prog(input ee_op_e op, input logic [8:0] a, input logic [15:0] d, input logic w);
      int t;
      t = len_of(op);
      issue(op, a, d, w);
      if (wel_m) begin
         check("R5 waits for deselect", busy, 1'b0);
         check("R5 last-bit variant starts", busy_e, 1'b1);
         nstep(t);
         check("R5 busy length", busy, 1'b1);
         nstep(1);
         check("R5 busy ends", busy, 1'b0);
         check("R5 last-bit variant ends", busy_e, 1'b0);
         model_apply(op, a, d, w);
      end else begin
         nstep(2);
         check("R1 ignored while disabled", busy, 1'b0);
         check("R1 ignored while disabled", busy_e, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [8:0]  a;
      logic [15:0] d;
      logic        w;
      void'($urandom(32'd7351));
      wel_m = 1'b0;
      nstep(3);
      rst_n = 1'b1;
      nstep(1);
      // R1: reset state
      check("R1 reset busy", busy, 1'b0);
      check("R1 reset sdo_en", sdo_en, 1'b0);
      run_prog(OP_CLEAR_ALL, 9'h0, 16'h0, 1'b1);

      issue(OP_WR_ENABLE, 9'h0, 16'h0, 1'b1);
      wel_m = 1'b1;
      nstep(2);
      // R3: clear-all
      run_prog(OP_CLEAR_ALL, 9'h0, 16'h0, 1'b1);
      for (int i = 0; i < 4; i++) read_chk("R3 clear-all", 9'($urandom), 1'b1);

      // R9/R4: random program-word in both widths
      for (int i = 0; i < 14; i++) begin
         a = 9'($urandom); d = 16'($urandom); w = 1'($urandom);
         run_prog(OP_PROG_WORD, a, d, w);
         read_chk("R9 program readback", a, w);
         read_chk("R9 other word", 9'($urandom), 1'($urandom));
      end

      // R2: disable blocks programming, reads still work
      issue(OP_WR_DISABLE, 9'h0, 16'h0, 1'b1);
      wel_m = 1'b0;
      nstep(2);
      run_prog(OP_PROG_WORD, 9'h003, 16'hDEAD, 1'b1);
      read_chk("R2 disabled write ignored", 9'h003, 1'b1);
      run_prog(OP_PROG_ALL, 9'h000, 16'hBEEF, 1'b1);
      read_chk("R2 read while disabled", 9'h0F3, 1'b1);
      issue(OP_WR_ENABLE, 9'h0, 16'h0, 1'b1);
      wel_m = 1'b1;
      nstep(2);

      // R4: auto-erase phase before program
      run_prog(OP_PROG_WORD, 9'h007, 16'h1234, 1'b1);
      issue(OP_PROG_WORD, 9'h007, 16'hABCD, 1'b1);
      wide_mode = 1'b1; rd_addr = 9'h007;
      nstep(T_W/2 + 1);
      check("R4 erased mid-cycle", rd_data, 16'hFFFF);
      nstep(T_W/2);
      check("R4 programmed at end", rd_data, 16'hABCD);
      model_apply(OP_PROG_WORD, 9'h007, 16'hABCD, 1'b1);
      nstep(2);

      // R3: clear single word, x16 and x8
      run_prog(OP_PROG_WORD, 9'h006, 16'h0F0F, 1'b1);
      run_prog(OP_CLEAR_WORD, 9'h007, 16'h0, 1'b1);
      read_chk("R3 clear word", 9'h007, 1'b1);
      read_chk("R3 neighbour kept", 9'h006, 1'b1);
      run_prog(OP_PROG_WORD, 9'h00A, 16'h2468, 1'b1);
      run_prog(OP_CLEAR_WORD, 9'd21, 16'h0, 1'b0);
      read_chk("R3 clear upper byte", 9'd21, 1'b0);
      read_chk("R3 lower byte kept", 9'd20, 1'b0);
      read_chk("R9 byte lanes in word", 9'h00A, 1'b1);

      // R4: program-all in both widths
      run_prog(OP_PROG_ALL, 9'h0, 16'h00A5, 1'b0);
      for (int i = 0; i < 4; i++) read_chk("R4 program-all x8", 9'($urandom), 1'($urandom));
      run_prog(OP_PROG_ALL, 9'h0, 16'h3C69, 1'b1);
      for (int i = 0; i < 4; i++) read_chk("R4 program-all x16", 9'($urandom), 1'($urandom));

      // R10/R7: command while busy is dropped, select toggling ignored
      issue(OP_PROG_WORD, 9'h009, 16'h1111, 1'b1);
      nstep(5);
      issue(OP_PROG_WORD, 9'h009, 16'h2222, 1'b1);
      nstep(T_W - 8);
      check("R7 busy kept through select toggles", busy, 1'b1);
      nstep(1);
      check("R10 length unchanged", busy, 1'b0);
      model_apply(OP_PROG_WORD, 9'h009, 16'h1111, 1'b1);
      read_chk("R10 busy command dropped", 9'h009, 1'b1);

      // R6: status on data-out
      issue(OP_PROG_WORD, 9'h040, 16'h7777, 1'b1);
      nstep(MINL + 1);
      chip_sel = 1'b1;
      nstep(1);
      check("R6 status driven", sdo_en, 1'b1);
      check("R6 busy reads 0", sdo_val, 1'b0);
      while (busy) nstep(1);
      nstep(1);
      check("R6 still driven", sdo_en, 1'b1);
      check("R6 ready reads 1", sdo_val, 1'b1);
      model_apply(OP_PROG_WORD, 9'h040, 16'h7777, 1'b1);
      chip_sel = 1'b0;
      #1;
      check("R6 released on deselect", sdo_en, 1'b0);
      nstep(2);
      chip_sel = 1'b1;
      nstep(1);
      check("R6 short low gives no status", sdo_en, 1'b0);
      chip_sel = 1'b0;
      nstep(MINL + 1);
      chip_sel = 1'b1;
      nstep(1);
      check("R6 status after long low", sdo_en, 1'b1);
      check("R6 ready value", sdo_val, 1'b1);

      // R8: start bit then deselect clears the status
      start_bit = 1'b1;
      nstep(1);
      start_bit = 1'b0;
      chip_sel = 1'b0;
      nstep(MINL + 2);
      chip_sel = 1'b1;
      nstep(1);
      check("R8 status withdrawn", sdo_en, 1'b0);
      chip_sel = 1'b0;
      nstep(2);
      read_chk("R8 data intact", 9'h040, 1'b1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule